// File: doc/BRIEF.md
# Center-Aligned Digital Pulse Width Modulator with Sample Trigger

This block drives one power-switch gate from a triangular carrier that climbs from zero to a programmed period value and falls back to zero. The gate is on while the carrier sits below a compare value, so the on-time is centred on the carrier valley. The compare value comes from a wide duty word written by the control loop; only its upper counter-width bits are kept. The modulator therefore acts close to a pure delay of half a modulation period.

Two strobes pace the surrounding controller. A period-start pulse marks each valley so the control algorithm can begin its next iteration. A converter start pulse fires at the valley, which is the centre of the on-time. In double update mode it also fires at the peak, which is the centre of the off-time. Sampling at these instants makes the measured ripple current equal its period average.

The duty, period and mode inputs are captured only at carrier turning points. In single update mode they are captured at the valley. In double update mode the duty is captured at both valley and peak. A new value therefore never cuts into a half-period that has already started.

Top module: `cdpwm_top`

## Requirements
- R1: While reset is asserted, and while the enable has not yet been sampled high, gate_o, sample_o and period_start_o are all 0.
- R2: With a captured period P, the carrier visits 0,1,…,P,P-1,…,1 and repeats, so one modulation period lasts exactly 2·P clock cycles.
- R3: The gate is high in exactly the cycles where the carrier is below the captured compare value C. For 0<C<P this gives 2·C-1 high cycles per period, centred on the valley.
- R4: C=0 keeps the gate low for the whole period. C≥P keeps it high for all 2·P cycles.
- R5: C is the duty word shifted right by DUTY_W-CNT_W bits, so the low fraction bits are discarded. For example, 5 with all six fraction bits set gives C=5.
- R6: In single update mode (dbl_mode_i=0), duty_i, period_i and dbl_mode_i are captured only on the clock edge that enters the valley. A change made after a valley has no effect until the following valley.
- R7: In double update mode, the compare value is also reloaded on the edge that enters the peak. The falling half then uses the duty present at that edge.
- R8: sample_o is a one-cycle pulse at each valley. In double update mode, captured at the valley, there is an additional one-cycle pulse at the peak: 1 pulse per period in single mode, 2 in double.
- R9: period_start_o is high for exactly the one valley cycle of each period.
- R10: When en_i is sampled low, all outputs are 0 from the next cycle and the carrier returns to 0. When en_i is next sampled high, the following cycle is a valley, with period_start_o and sample_o both high.
- R11: A period_i of 0 is captured as 1, giving a period of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low parks the carrier at 0 |
| period_i | input | CNT_W | Carrier peak value, captured at the valley |
| duty_i | input | DUTY_W | Duty word with DUTY_W-CNT_W fraction bits |
| dbl_mode_i | input | 1 | 1 selects double update, captured at the valley |
| gate_o | output | 1 | Switch gate command |
| sample_o | output | 1 | Converter start-of-conversion pulse |
| period_start_o | output | 1 | Valley strobe that starts a control iteration |

## Verification
A carrier that skips or repeats a count shows up immediately as a period-start spacing other than 2·P. A carrier stuck at the wrong turning point shows up as a gate high count other than 2·C-1 within the same period. A compare register reloaded at the wrong instant only shows up when the duty changes inside a period: the gate count of that period departs from 7 (single update) or 11 (double update). The bench therefore changes inputs right after a valley. A wrong mode capture changes the number of converter pulses within one period. The per-cycle reference model flags any such divergence on the cycle it first reaches a port.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;
endpackage

// File: rtl/dpwm_carrier.sv
`timescale 1ns/1ps
module dpwm_carrier
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             valley_ld_o,
  output logic             peak_ent_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_inc;
  dir_e             dir_q, dir_nxt;
  logic             run_q, run_nxt;

  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    run_nxt = run_q;
    if (!en_i) begin
      cnt_nxt = '0;
      dir_nxt = DIR_UP;
      run_nxt = 1'b0;
    end else if (!run_q) begin
      cnt_nxt = '0;
      dir_nxt = DIR_UP;
      run_nxt = 1'b1;
    end else if (dir_q == DIR_UP) begin
      cnt_nxt = cnt_inc;
      dir_nxt = (cnt_inc == prd_i) ? DIR_DN : DIR_UP;
    end else begin
      cnt_nxt = cnt_q - ONE;
      dir_nxt = (cnt_q == ONE) ? DIR_UP : DIR_DN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
      run_q <= run_nxt;
    end
  end

  assign valley_ld_o = !en_i || !run_q || (dir_q == DIR_DN && cnt_q == ONE);
  assign peak_ent_o  = en_i && run_q && (dir_q == DIR_UP) && (cnt_inc == prd_i);
  assign cnt_o       = cnt_q;
  assign run_o       = run_q;
endmodule

// File: rtl/dpwm_shadow.sv
`timescale 1ns/1ps
module dpwm_shadow #(
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valley_ld_i,
  input  logic              peak_ent_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              dbl_mode_i,
  output logic [CNT_W-1:0]  prd_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              full_o,
  output logic              dbl_o
);
  localparam int FRAC_W = DUTY_W - CNT_W;

  logic [CNT_W-1:0] prd_q, prd_nxt, prd_cap;
  logic [CNT_W-1:0] cmp_q, cmp_nxt;
  logic             full_q, full_nxt;
  logic             dbl_q, dbl_nxt;
  logic             cmp_en, shd_en;
  logic             full_at_valley, full_at_peak;

  assign prd_cap        = (period_i == '0) ? CNT_W'(1) : period_i;
  assign full_at_valley = duty_i >= {prd_cap, {FRAC_W{1'b0}}};
  assign full_at_peak   = duty_i >= {prd_q, {FRAC_W{1'b0}}};
  assign shd_en         = valley_ld_i;
  assign cmp_en         = valley_ld_i || (peak_ent_i && dbl_q);

  always_comb begin
    prd_nxt  = shd_en ? prd_cap : prd_q;
    dbl_nxt  = shd_en ? dbl_mode_i : dbl_q;
    cmp_nxt  = cmp_en ? duty_i[DUTY_W-1 -: CNT_W] : cmp_q;
    full_nxt = full_q;
    if (valley_ld_i)      full_nxt = full_at_valley;
    else if (cmp_en)      full_nxt = full_at_peak;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q  <= CNT_W'(1);
      cmp_q  <= '0;
      full_q <= 1'b0;
      dbl_q  <= 1'b0;
    end else begin
      prd_q  <= prd_nxt;
      cmp_q  <= cmp_nxt;
      full_q <= full_nxt;
      dbl_q  <= dbl_nxt;
    end
  end

  assign prd_o  = prd_q;
  assign cmp_o  = cmp_q;
  assign full_o = full_q;
  assign dbl_o  = dbl_q;
endmodule

// File: rtl/dpwm_outstage.sv
`timescale 1ns/1ps
module dpwm_outstage #(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             full_i,
  input  logic             dbl_i,
  input  logic             run_i,
  output logic             gate_o,
  output logic             sample_o,
  output logic             period_start_o
);
  logic at_valley, at_peak;

  assign at_valley      = run_i && (cnt_i == '0);
  assign at_peak        = run_i && (cnt_i == prd_i);
  assign gate_o         = run_i && (full_i || (cnt_i < cmp_i));
  assign period_start_o = at_valley;
  assign sample_o       = at_valley || (dbl_i && at_peak);
endmodule

// File: rtl/cdpwm_top.sv
`timescale 1ns/1ps
module cdpwm_top #(
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              dbl_mode_i,
  output logic              gate_o,
  output logic              sample_o,
  output logic              period_start_o
);
  logic [CNT_W-1:0] cnt_w, prd_w, cmp_w;
  logic             run_w, valley_ld_w, peak_ent_w, full_w, dbl_w;

  dpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .prd_i       (prd_w),
    .cnt_o       (cnt_w),
    .run_o       (run_w),
    .valley_ld_o (valley_ld_w),
    .peak_ent_o  (peak_ent_w)
  );

  dpwm_shadow #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .valley_ld_i (valley_ld_w),
    .peak_ent_i  (peak_ent_w),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .dbl_mode_i  (dbl_mode_i),
    .prd_o       (prd_w),
    .cmp_o       (cmp_w),
    .full_o      (full_w),
    .dbl_o       (dbl_w)
  );

  dpwm_outstage #(.CNT_W(CNT_W)) u_out (
    .cnt_i          (cnt_w),
    .prd_i          (prd_w),
    .cmp_i          (cmp_w),
    .full_i         (full_w),
    .dbl_i          (dbl_w),
    .run_i          (run_w),
    .gate_o         (gate_o),
    .sample_o       (sample_o),
    .period_start_o (period_start_o)
  );
endmodule

// File: rtl/cdpwm_chk.sv
`timescale 1ns/1ps
module cdpwm_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             gate_o,
  input logic             sample_o,
  input logic             period_start_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd,
  input logic [CNT_W-1:0] cmp,
  input logic             run
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= prd); // R2
  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (run && $past(run)) |-> (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) || ({1'b0, $past(cnt)} == {1'b0, cnt} + 1'b1))); // R2
  AST_CMP_AT_TURN: assert property (@(posedge clk) disable iff (!rst_n) (run && !$stable(cmp)) |-> (cnt == '0 || cnt == prd)); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) period_start_o |=> !period_start_o); // R9
  AST_SAMPLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n) period_start_o |-> sample_o); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en_i |=> (!gate_o && !sample_o && !period_start_o)); // R10
endmodule

bind cdpwm_top cdpwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en_i           (en_i),
  .gate_o         (gate_o),
  .sample_o       (sample_o),
  .period_start_o (period_start_o),
  .cnt            (cnt_w),
  .prd            (prd_w),
  .cmp            (cmp_w),
  .run            (run_w)
);

// File: tb/sim_cdpwm_top.sv
`timescale 1ns/1ps
module sim_cdpwm_top;
  localparam int CW = 10;
  localparam int DW = 16;
  localparam int FR = DW - CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] period = CW'(10);
  logic [DW-1:0] duty = '0;
  logic          dbl = 1'b0;
  logic          gate_o, sample_o, period_start_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R3";

  int m_cnt, m_up, m_run, m_cmp, m_prd, m_dbl, dq;

  always #2.5 clk = ~clk;

  cdpwm_top #(.CNT_W(CW), .DUTY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .period_i(period), .duty_i(duty),
    .dbl_mode_i(dbl), .gate_o(gate_o), .sample_o(sample_o), .period_start_o(period_start_o)
  );

  function automatic logic [DW-1:0] dv(int c);
    return DW'(c << FR);
  endfunction

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_run = 0; m_cmp = 0; m_prd = 1; m_dbl = 0;
    end else begin
      dq = int'(duty) >> FR;
      if (!en || !m_run) begin
        m_run = en ? 1 : 0;
        m_cnt = 0; m_up = 1;
        m_cmp = dq; m_prd = (period == 0) ? 1 : int'(period); m_dbl = dbl;
      end else if (m_up != 0) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == m_prd) begin
          m_up = 0;
          if (m_dbl != 0) m_cmp = dq;
        end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_up = 1;
          m_cmp = dq; m_prd = (period == 0) ? 1 : int'(period); m_dbl = dbl;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(gate_o), (m_run != 0 && (m_cmp >= m_prd || m_cnt < m_cmp)) ? 1 : 0, cur_req, "gate vs model");
      chk(int'(sample_o), (m_run != 0 && (m_cnt == 0 || (m_dbl != 0 && m_cnt == m_prd))) ? 1 : 0, "R8", "sample vs model");
      chk(int'(period_start_o), (m_run != 0 && m_cnt == 0) ? 1 : 0, "R9", "period_start vs model");
    end
  end

  task automatic count_period(output int len, output int highs, output int smp);
    len = 0; highs = 0; smp = 0;
    do begin
      len++;
      highs += int'(gate_o);
      smp += int'(sample_o);
      @(negedge clk);
    end while (!period_start_o);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_test();
  end

  initial begin
    int len, hi, sm;
    repeat (3) begin
      @(negedge clk);
      chk(int'(gate_o) + int'(sample_o) + int'(period_start_o), 0, "R1", "outputs in reset");
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(gate_o) + int'(sample_o) + int'(period_start_o), 0, "R1", "outputs before enable");

    cur_req = "R3";
    en = 1'b1; duty = dv(4);
    @(negedge clk);
    chk(int'(period_start_o), 1, "R10", "first cycle after enable is valley");
    count_period(len, hi, sm);
    chk(len, 20, "R2", "period length P=10");
    chk(hi, 7, "R3", "gate cycles C=4");
    chk(sm, 1, "R8", "samples single mode");
    count_period(len, hi, sm);
    chk(len, 20, "R9", "period_start spacing");

    cur_req = "R4";
    duty = '0;   count_period(len, hi, sm); count_period(len, hi, sm);
    chk(hi, 0, "R4", "gate cycles C=0");
    duty = dv(10); count_period(len, hi, sm); count_period(len, hi, sm);
    chk(hi, 20, "R4", "gate cycles C=P");
    duty = dv(1); count_period(len, hi, sm); count_period(len, hi, sm);
    chk(hi, 1, "R3", "gate cycles C=1");

    cur_req = "R5";
    duty = dv(5) + DW'(63); count_period(len, hi, sm); count_period(len, hi, sm);
    chk(hi, 9, "R5", "fraction bits dropped");

    cur_req = "R6";
    duty = dv(4); count_period(len, hi, sm); count_period(len, hi, sm);
    duty = dv(8); period = CW'(6);
    count_period(len, hi, sm);
    chk(len, 20, "R6", "period unchanged mid-period");
    chk(hi, 7, "R6", "duty unchanged mid-period");
    count_period(len, hi, sm);
    chk(len, 12, "R6", "new period after valley");
    chk(hi, 12, "R6", "new duty after valley");

    cur_req = "R7";
    period = CW'(10); duty = dv(4); dbl = 1'b1;
    count_period(len, hi, sm); count_period(len, hi, sm);
    chk(sm, 2, "R8", "samples double mode");
    chk(hi, 7, "R7", "double mode steady duty");
    duty = dv(8);
    count_period(len, hi, sm);
    chk(hi, 11, "R7", "peak reload in double mode");

    cur_req = "R10";
    dbl = 1'b0;
    repeat (5) @(negedge clk);
    en = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(int'(gate_o) + int'(sample_o) + int'(period_start_o), 0, "R10", "outputs when disabled");
    end
    en = 1'b1;
    @(negedge clk);
    chk(int'(period_start_o), 1, "R10", "period_start after re-enable");
    chk(int'(sample_o), 1, "R10", "sample after re-enable");

    cur_req = "R11";
    period = '0;
    count_period(len, hi, sm); count_period(len, hi, sm);
    chk(len, 2, "R11", "zero period treated as one");

    repeat (4) @(negedge clk);
    finish_test();
  end
endmodule